// File: doc/BRIEF.md
# Bus Handshake Gap Watchdog

This block guards a parallel peripheral bus against a stalled transfer. It watches one handshake strobe and measures the time from one rising edge of that strobe to the next, counted in pulses of a prescaled time tick supplied from outside. When the bus side plays the target role the request strobe is watched; in the initiator role the acknowledge strobe is watched. If the selected number of ticks passes with no new strobe edge, a sticky timeout flag is set and, when enabled, an interrupt is raised.

The allowed gap comes from a 4-bit code held in an 8-bit timer register. The same register carries a second 4-bit code that belongs to a selection/reselection timer elsewhere; here it is only stored and read back. Both strobes pass through a two-flop synchronizer, so they may come straight from pins. Counting takes place only while the transfer-phase input is high. There is no data stream at this block's edge, so every pin is a plain level or single-cycle pulse with no valid/ready handshake and no back-pressure.

Top module: `hs_gap_watchdog`

## Requirements
- R1: The timer register is 8 bits wide, reads back the last value written through reg_wr_en/reg_wr_data on the following cycle, and is 0x00 after reset. Bits [7:4] are the gap code; bits [3:0] are the selection code, which is stored and readable but drives nothing in this block.
- R2: A gap code of 0 disables the watchdog: no timeout occurs however many ticks pass.
- R3: A nonzero gap code n allows 2^(n-1) ticks. After a restart, gap_timeout stays low through tick number 2^(n-1)-1 and goes high on the clock edge that samples tick number 2^(n-1).
- R4: With role_target=1 rising edges of req_strobe restart the count and ack_strobe is ignored; with role_target=0 the roles of the two strobes swap. Strobes are active high, and a rising edge presented before clock edge k takes effect on edge k+2 (two synchronizer stages plus edge detection).
- R5: A timeout sets gap_timeout, which stays high until cleared.
- R6: A one-cycle pulse on status_clr clears gap_timeout on the next edge; when a timeout and a clear coincide, the flag ends up set.
- R7: irq is high exactly when gap_timeout and irq_en are both high.
- R8: While phase_active is low the count is held at zero and disarmed: no timeout occurs, and after phase_active returns high timing starts only from the next monitored strobe edge.
- R9: After a timeout the count stops; no further timeout occurs until a new monitored strobe edge.
- R10: A write to the gap code takes effect at once: if the ticks already counted reach the new limit, the next tick causes a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Write strobe for the timer register |
| reg_wr_data | input | 8 | Write value: [7:4] gap code, [3:0] selection code |
| reg_rd_data | output | 8 | Current timer register value |
| role_target | input | 1 | 1 selects target role (watch request), 0 initiator role (watch acknowledge) |
| req_strobe | input | 1 | Bus request strobe, active high, asynchronous |
| ack_strobe | input | 1 | Bus acknowledge strobe, active high, asynchronous |
| phase_active | input | 1 | High while a transfer phase is in progress |
| tick | input | 1 | Prescaled time tick, one-cycle pulse |
| irq_en | input | 1 | Interrupt enable |
| status_clr | input | 1 | Write-one-to-clear pulse for the timeout flag |
| gap_timeout | output | 1 | Sticky handshake timeout flag |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the local rules of the counter and flag: a zero code never fires, a restart arms and zeroes the count, an idle phase clears it, the count only moves on a tick, firing disarms the counter, and the flag's set, hold and clear behaviour. Only the bench scenarios can show the end-to-end timing: that the timeout lands on exactly the 2^(n-1)-th tick after the strobe edge and not one early, that the unmonitored strobe leaves a running count untouched, that a lowered code cuts a running gap short, and that the two-cycle synchronizer latency lines up with a reference model over long random runs.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  localparam int HSW_CODE_W = 4;
  localparam int HSW_REG_W  = 2 * HSW_CODE_W;
  localparam int HSW_CNT_W  = (1 << HSW_CODE_W) - 1;

  typedef struct packed {
    logic [HSW_CODE_W-1:0] gap_code;
    logic [HSW_CODE_W-1:0] sel_code;
  } hsw_timer_reg_t;

  typedef enum logic {
    ROLE_INITIATOR = 1'b0,
    ROLE_TARGET    = 1'b1
  } hsw_role_e;
endpackage

// File: rtl/hsw_edge_sync.sv
module hsw_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-1:0], din};
  end

  assign rise = shift_q[STAGES-1] & ~shift_q[STAGES];
endmodule

// File: rtl/hsw_gap_counter.sv
module hsw_gap_counter
  import hsw_pkg::*;
#(
  parameter int CODE_W = HSW_CODE_W,
  parameter int CNT_W  = HSW_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              phase_active,
  input  logic              restart,
  input  logic              tick,
  output logic              fire
);
  logic [CNT_W-1:0] cnt_q, limit, cnt_inc;
  logic             armed_q, reached;

  always_comb begin
    limit   = (code == '0) ? '0 : (CNT_W'(1) << (code - CODE_W'(1)));
    cnt_inc = cnt_q + CNT_W'(1);
    reached = (cnt_inc >= limit);
    fire    = phase_active & ~restart & armed_q & tick & (code != '0) & reached;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!phase_active) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (restart) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (fire) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (armed_q && tick && code != '0) begin
      cnt_q   <= cnt_inc;
    end
  end

  p_code0_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0) |-> !fire);
  p_count_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_active && !restart && !tick) |=> $stable(cnt_q));
  p_restart_arms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_active && restart) |=> (armed_q && cnt_q == '0));
  p_idle_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_active |=> (!armed_q && cnt_q == '0));
  p_fire_disarms_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed_q);
endmodule

// File: rtl/hsw_status.sv
module hsw_status (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic clr,
  input  logic irq_en,
  output logic status,
  output logic irq
);
  logic status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    status_q <= 1'b0;
    else if (fire) status_q <= 1'b1;
    else if (clr)  status_q <= 1'b0;
  end

  assign status = status_q;
  assign irq    = status_q & irq_en;

  p_set_on_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> status_q);
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !clr) |=> status_q);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fire) |=> !status_q);
endmodule

// File: rtl/hs_gap_watchdog.sv
module hs_gap_watchdog
  import hsw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [HSW_REG_W-1:0] reg_wr_data,
  output logic [HSW_REG_W-1:0] reg_rd_data,
  input  logic                 role_target,
  input  logic                 req_strobe,
  input  logic                 ack_strobe,
  input  logic                 phase_active,
  input  logic                 tick,
  input  logic                 irq_en,
  input  logic                 status_clr,
  output logic                 gap_timeout,
  output logic                 irq
);
  localparam int NSTROBE = 2;

  hsw_timer_reg_t     tmr_q;
  logic [NSTROBE-1:0] strobe_raw, strobe_rise;
  logic               restart, fire;
  hsw_role_e          role;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tmr_q <= '0;
    else if (reg_wr_en) tmr_q <= hsw_timer_reg_t'(reg_wr_data);
  end
  assign reg_rd_data = tmr_q;

  assign strobe_raw = {req_strobe, ack_strobe};

  for (genvar g = 0; g < NSTROBE; g++) begin : g_sync
    hsw_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (strobe_raw[g]),
      .rise (strobe_rise[g])
    );
  end

  assign role    = hsw_role_e'(role_target);
  assign restart = (role == ROLE_TARGET) ? strobe_rise[1] : strobe_rise[0];

  hsw_gap_counter i_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .code        (tmr_q.gap_code),
    .phase_active(phase_active),
    .restart     (restart),
    .tick        (tick),
    .fire        (fire)
  );

  hsw_status i_status (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .clr   (status_clr),
    .irq_en(irq_en),
    .status(gap_timeout),
    .irq   (irq)
  );

  p_reg_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> (reg_rd_data == $past(reg_wr_data)));
  p_reg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> $stable(reg_rd_data));
endmodule

// File: tb/test_hs_gap_watchdog.sv
`timescale 1ns/1ps
module test_hs_gap_watchdog;
  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0;
  logic [7:0] reg_wr_data = 0, reg_rd_data;
  logic role_target = 1, req_strobe = 0, ack_strobe = 0;
  logic phase_active = 0, tick = 0, irq_en = 0, status_clr = 0;
  logic gap_timeout, irq;
  int total = 0, bad = 0;
  bit model_on = 0;

  always #5 clk = ~clk;

  hs_gap_watchdog i_hs_gap_watchdog (.*);

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lim(int code);
    return (code == 0) ? 0 : (1 << (code - 1));
  endfunction

  // reference model built from the requirements
  logic [2:0] m_rq = 0, m_ak = 0;
  int m_cnt = 0;
  bit m_arm = 0, m_st = 0;
  logic [7:0] m_reg = 0;

  always @(posedge clk) begin
    bit er, ea, sel, fr;
    if (!rst_n) begin
      m_rq <= 0; m_ak <= 0; m_cnt <= 0; m_arm <= 0; m_st <= 0; m_reg <= 0;
    end else begin
      er = m_rq[1] & ~m_rq[2];
      ea = m_ak[1] & ~m_ak[2];
      sel = role_target ? er : ea;
      fr = 0;
      if (!phase_active) begin m_cnt <= 0; m_arm <= 0; end
      else if (sel) begin m_cnt <= 0; m_arm <= 1; end
      else if (m_arm && tick && m_reg[7:4] != 0) begin
        if (m_cnt + 1 >= lim(int'(m_reg[7:4]))) begin fr = 1; m_arm <= 0; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end
      m_st <= fr ? 1'b1 : (status_clr ? 1'b0 : m_st);
      if (reg_wr_en) m_reg <= reg_wr_data;
      m_rq <= {m_rq[1:0], req_strobe};
      m_ak <= {m_ak[1:0], ack_strobe};
    end
  end

  always @(posedge clk) begin
    #2;
    if (model_on) begin
      chk("R5 model status", gap_timeout, m_st);
      chk("R7 model irq", irq, m_st & irq_en);
      chk("R1 model register", reg_rd_data, m_reg);
    end
  end

  task automatic pulse(input bit on_req);
    @(negedge clk);
    if (on_req) req_strobe = 1; else ack_strobe = 1;
    @(negedge clk);
    req_strobe = 0; ack_strobe = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr_en = 1; reg_wr_data = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic clear;
    @(negedge clk); status_clr = 1;
    @(negedge clk); status_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset register", reg_rd_data, 0);
    chk("R5 reset flag", gap_timeout, 0);
    chk("R7 reset irq", irq, 0);
    rst_n = 1;
    model_on = 1;

    wr(8'h3A);
    chk("R1 readback", reg_rd_data, 8'h3A);

    // R3: code 3 allows 4 ticks
    wr(8'h35); role_target = 1; phase_active = 1; irq_en = 1;
    pulse(1);
    ticks(lim(3) - 1);
    chk("R3 no early timeout", gap_timeout, 0);
    ticks(1);
    chk("R3 timeout on last tick", gap_timeout, 1);
    chk("R7 irq enabled", irq, 1);
    @(negedge clk); irq_en = 0; #1;
    chk("R7 irq masked", irq, 0);
    irq_en = 1;

    clear();
    chk("R6 cleared", gap_timeout, 0);
    ticks(8);
    chk("R9 no retrigger", gap_timeout, 0);

    // R4: unmonitored strobe does not restart
    pulse(1); ticks(3); pulse(0); ticks(1);
    chk("R4 ack ignored in target role", gap_timeout, 1);
    clear();
    @(negedge clk); role_target = 0;
    pulse(0); ticks(3); pulse(0); ticks(3);
    chk("R4 ack restarts in initiator role", gap_timeout, 0);
    ticks(1);
    chk("R4 timeout after restart", gap_timeout, 1);
    clear();

    wr(8'h0F);
    chk("R1 selection code readable", reg_rd_data, 8'h0F);
    pulse(0); ticks(20);
    chk("R2 code zero disabled", gap_timeout, 0);

    // R8: idle phase
    wr(8'h10);
    @(negedge clk); phase_active = 0;
    pulse(0); ticks(4);
    chk("R8 no timeout while idle", gap_timeout, 0);
    @(negedge clk); phase_active = 1;
    ticks(3);
    chk("R8 disarmed after idle", gap_timeout, 0);
    pulse(0); ticks(1);
    chk("R8 resumes after strobe", gap_timeout, 1);
    clear();

    // R6: set wins over clear
    pulse(0);
    @(negedge clk); tick = 1; status_clr = 1;
    @(negedge clk); tick = 0; status_clr = 0;
    chk("R6 set wins over clear", gap_timeout, 1);
    clear();

    // R10: lowering the code mid-gap
    wr(8'h45); pulse(0); ticks(5);
    chk("R10 before code change", gap_timeout, 0);
    wr(8'h25); ticks(1);
    chk("R10 new code applies at once", gap_timeout, 1);
    clear();

    // constrained random against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom % 64 == 0) role_target = ~role_target;
      req_strobe   = ($urandom % 4 == 0);
      ack_strobe   = ($urandom % 4 == 0);
      phase_active = ($urandom % 16 != 0);
      tick         = ($urandom % 3 == 0);
      status_clr   = ($urandom % 20 == 0);
      irq_en       = $urandom % 2;
      reg_wr_en    = ($urandom % 50 == 0);
      reg_wr_data  = {4'($urandom % 5), 4'($urandom)};
    end
    @(negedge clk);
    reg_wr_en = 0; tick = 0; status_clr = 0;
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule